// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a virtual address by searching a hashed page table held in on-chip memory. The virtual page number (VPN) of the request is folded into a bucket index. The head pointer of that bucket is read, and the block then follows a singly linked chain of elements. Each element holds a VPN, a frame number and the pointer to the next element. Elements are compared one at a time, in chain order. If an element matches, the block returns the physical address. If the chain runs out without a match, it reports a miss. If the walk grows longer than a set limit, it stops and reports an error. This guards against a corrupted or circular chain.

A requester presents an address with a valid/ready handshake. The result stays on the response port until the consumer accepts it. The block drives two synchronous read ports with one-cycle latency: one into the bucket head table and one into the element store. It never writes either memory. Software or other logic builds the table.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and neither `hd_en` nor `el_en` is asserted until a request is accepted.
- R2: The bucket index on `hd_addr` is the XOR of the VPN split into BKT_W-bit chunks, with chunk 0 taken from the lowest VPN bits and the top chunk zero-padded. The head read is issued in the cycle after the request is accepted. The VPN is the upper VPN_W bits of `req_va`; the offset is the lower OFF_W bits.
- R3: A head pointer of all ones is the null pointer. When the bucket head is null, the block replies miss with a hop count of 0 and issues no element read.
- R4: An element word is {vpn, pfn, next}, packed from MSB to LSB. The first element examined is the one the head pointer names. After it, each `next` field names the following element.
- R5: On the first element whose VPN equals the request VPN, the reply has status 0 (hit). It carries `rsp_pa` = {pfn, request offset} and `rsp_hops` equal to the 1-based position of that element in the chain.
- R6: When an element does not match and its `next` field is null, the reply has status 1 (miss), `rsp_pa` = 0, and `rsp_hops` equal to the number of elements read.
- R7: When MAX_HOPS elements have been read without a match and the last one has a non-null `next`, the reply has status 2 (limit), `rsp_pa` = 0 and `rsp_hops` = MAX_HOPS. A match on element MAX_HOPS is still a hit.
- R8: `rsp_valid` and all response fields hold steady until `rsp_ready` is seen high on a clock edge. `req_ready` stays low from acceptance until the response is taken.
- R9: Each element examined costs exactly one `el_en` read, so the element reads per request equal `rsp_hops`. Head and element reads are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_va | input | VPN_W+OFF_W | Virtual address: VPN above the page offset |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Consumer takes the reply |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 walk limit reached |
| rsp_pa | output | PFN_W+OFF_W | Physical address on hit, zero otherwise |
| rsp_hops | output | $clog2(MAX_HOPS+1) | Number of elements read during the walk |
| hd_en | output | 1 | Head table read strobe |
| hd_addr | output | BKT_W | Bucket index for the head read |
| hd_ptr | input | PTR_W | Head pointer, valid one cycle after `hd_en` |
| el_en | output | 1 | Element store read strobe |
| el_addr | output | PTR_W | Element index for the read |
| el_word | input | VPN_W+PFN_W+PTR_W | Element {vpn, pfn, next}, valid one cycle after `el_en` |

## Verification
The assertions assume both memories answer exactly one cycle after their strobe and keep their data stable until the next strobe. They also assume `rsp_ready` may be dropped at any time without further effect. The bench memory models update only on a strobe, and the response consumer inserts random stall cycles before it accepts. The table contents are never changed during a walk; the bench rebuilds them only between requests. Circular and over-long chains are built on purpose, so the limit path runs under the same assumptions as normal walks.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [1:0] {
      WALK_HIT   = 2'd0,
      WALK_MISS  = 2'd1,
      WALK_LIMIT = 2'd2
   } walk_stat_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HEAD_RD,
      PH_HEAD_CHK,
      PH_ELEM_RD,
      PH_ELEM_CHK,
      PH_REPLY
   } walk_phase_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int VPN_W = 20,
   parameter int BKT_W = 4
) (
   input  logic [VPN_W-1:0] vpn,
   output logic [BKT_W-1:0] idx
);
   localparam int NCH  = (VPN_W + BKT_W - 1) / BKT_W;
   localparam int PADW = NCH * BKT_W;

   logic [PADW-1:0] padded;
   assign padded = PADW'(vpn);

   generate
      if (NCH == 1) begin : g_direct
         assign idx = padded[BKT_W-1:0];
      end else begin : g_fold
         logic [BKT_W-1:0] acc [NCH];
         assign acc[0] = padded[BKT_W-1:0];
         for (genvar c = 1; c < NCH; c++) begin : g_chunk
            assign acc[c] = acc[c-1] ^ padded[c*BKT_W +: BKT_W];
         end
         assign idx = acc[NCH-1];
      end
   endgenerate

endmodule

// File: rtl/hpt_elem_cmp.sv
module hpt_elem_cmp #(
   parameter int VPN_W = 20,
   parameter int PFN_W = 12,
   parameter int PTR_W = 6
) (
   input  logic [VPN_W+PFN_W+PTR_W-1:0] word,
   input  logic [VPN_W-1:0]             vpn_key,
   output logic                         hit,
   output logic [PFN_W-1:0]             pfn,
   output logic [PTR_W-1:0]             nxt,
   output logic                         nxt_null
);
   localparam logic [PTR_W-1:0] NULL_PTR = '1;

   logic [VPN_W-1:0] tag;

   assign tag      = word[PFN_W+PTR_W +: VPN_W];
   assign pfn      = word[PTR_W +: PFN_W];
   assign nxt      = word[PTR_W-1:0];
   assign hit      = (tag == vpn_key);
   assign nxt_null = (nxt == NULL_PTR);

endmodule

// File: rtl/hpt_walk_fsm.sv
module hpt_walk_fsm
   import hpt_pkg::*;
#(
   parameter int VPN_W    = 20,
   parameter int PFN_W    = 12,
   parameter int PTR_W    = 6,
   parameter int BKT_W    = 4,
   parameter int MAX_HOPS = 8,
   localparam int HOP_W   = $clog2(MAX_HOPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   output logic [VPN_W-1:0] vpn_q,
   input  logic [BKT_W-1:0] bucket,
   output logic             hd_en,
   output logic [BKT_W-1:0] hd_addr,
   input  logic [PTR_W-1:0] hd_ptr,
   output logic             el_en,
   output logic [PTR_W-1:0] el_addr,
   input  logic             el_hit,
   input  logic [PFN_W-1:0] el_pfn,
   input  logic [PTR_W-1:0] el_nxt,
   input  logic             el_nxt_null,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output walk_stat_e       rsp_status,
   output logic [PFN_W-1:0] rsp_pfn,
   output logic [HOP_W-1:0] rsp_hops
);
   localparam logic [PTR_W-1:0] NULL_PTR = '1;
   localparam logic [HOP_W-1:0] HOP_CAP  = HOP_W'(MAX_HOPS);

   walk_phase_e      phase;
   logic [PTR_W-1:0] cur_ptr;
   logic [HOP_W-1:0] hops;
   logic [HOP_W-1:0] hops_nx;
   walk_stat_e       stat_q;
   logic [PFN_W-1:0] pfn_q;

   assign hops_nx = hops + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cur_ptr <= '0;
         hops    <= '0;
         vpn_q   <= '0;
         stat_q  <= WALK_MISS;
         pfn_q   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (req_valid) begin
                  vpn_q <= req_vpn;
                  hops  <= '0;
                  phase <= PH_HEAD_RD;
               end
            end
            PH_HEAD_RD: phase <= PH_HEAD_CHK;
            PH_HEAD_CHK: begin
               if (hd_ptr == NULL_PTR) begin
                  stat_q <= WALK_MISS;
                  pfn_q  <= '0;
                  phase  <= PH_REPLY;
               end else begin
                  cur_ptr <= hd_ptr;
                  phase   <= PH_ELEM_RD;
               end
            end
            PH_ELEM_RD: phase <= PH_ELEM_CHK;
            PH_ELEM_CHK: begin
               hops <= hops_nx;
               if (el_hit) begin
                  stat_q <= WALK_HIT;
                  pfn_q  <= el_pfn;
                  phase  <= PH_REPLY;
               end else if (el_nxt_null) begin
                  stat_q <= WALK_MISS;
                  pfn_q  <= '0;
                  phase  <= PH_REPLY;
               end else if (hops_nx == HOP_CAP) begin
                  stat_q <= WALK_LIMIT;
                  pfn_q  <= '0;
                  phase  <= PH_REPLY;
               end else begin
                  cur_ptr <= el_nxt;
                  phase   <= PH_ELEM_RD;
               end
            end
            PH_REPLY: begin
               if (rsp_ready) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign req_ready  = (phase == PH_IDLE);
   assign hd_en      = (phase == PH_HEAD_RD);
   assign hd_addr    = bucket;
   assign el_en      = (phase == PH_ELEM_RD);
   assign el_addr    = cur_ptr;
   assign rsp_valid  = (phase == PH_REPLY);
   assign rsp_status = stat_q;
   assign rsp_pfn    = pfn_q;
   assign rsp_hops   = hops;

   // R8
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status)
                                  && $stable(rsp_pfn) && $stable(rsp_hops));
   // R8
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   // R3
   null_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      el_en |-> el_addr != NULL_PTR);
   // R7
   hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_hops <= HOP_CAP);
   // R7
   lim_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == WALK_LIMIT |-> rsp_hops == HOP_CAP);
   // R9
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hd_en && el_en));
   // R2
   head_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> hd_en);

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int VPN_W    = 20,
   parameter int PFN_W    = 12,
   parameter int OFF_W    = 12,
   parameter int PTR_W    = 6,
   parameter int BKT_W    = 4,
   parameter int MAX_HOPS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   output logic                           req_ready,
   input  logic [VPN_W+OFF_W-1:0]         req_va,
   output logic                           rsp_valid,
   input  logic                           rsp_ready,
   output logic [1:0]                     rsp_status,
   output logic [PFN_W+OFF_W-1:0]         rsp_pa,
   output logic [$clog2(MAX_HOPS+1)-1:0]  rsp_hops,
   output logic                           hd_en,
   output logic [BKT_W-1:0]               hd_addr,
   input  logic [PTR_W-1:0]               hd_ptr,
   output logic                           el_en,
   output logic [PTR_W-1:0]               el_addr,
   input  logic [VPN_W+PFN_W+PTR_W-1:0]   el_word
);
   localparam int HOP_W = $clog2(MAX_HOPS + 1);

   generate
      if (PTR_W < 2) begin : g_bad_ptr
         $error("PTR_W must be at least 2");
      end
      if (BKT_W < 1 || BKT_W > VPN_W) begin : g_bad_bkt
         $error("BKT_W must lie in 1..VPN_W");
      end
      if (MAX_HOPS < 1) begin : g_bad_hops
         $error("MAX_HOPS must be positive");
      end
   endgenerate

   logic [VPN_W-1:0] vpn_q;
   logic [OFF_W-1:0] off_q;
   logic [BKT_W-1:0] bucket;
   logic             c_hit;
   logic [PFN_W-1:0] c_pfn;
   logic [PTR_W-1:0] c_nxt;
   logic             c_nxt_null;
   walk_stat_e       stat;
   logic [PFN_W-1:0] pfn_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) off_q <= '0;
      else if (req_valid && req_ready) off_q <= req_va[OFF_W-1:0];
   end

   hpt_hash #(.VPN_W(VPN_W), .BKT_W(BKT_W)) u_hash (
      .vpn (vpn_q),
      .idx (bucket)
   );

   hpt_elem_cmp #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PTR_W(PTR_W)) u_cmp (
      .word     (el_word),
      .vpn_key  (vpn_q),
      .hit      (c_hit),
      .pfn      (c_pfn),
      .nxt      (c_nxt),
      .nxt_null (c_nxt_null)
   );

   hpt_walk_fsm #(
      .VPN_W(VPN_W), .PFN_W(PFN_W), .PTR_W(PTR_W),
      .BKT_W(BKT_W), .MAX_HOPS(MAX_HOPS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_vpn     (req_va[OFF_W +: VPN_W]),
      .vpn_q       (vpn_q),
      .bucket      (bucket),
      .hd_en       (hd_en),
      .hd_addr     (hd_addr),
      .hd_ptr      (hd_ptr),
      .el_en       (el_en),
      .el_addr     (el_addr),
      .el_hit      (c_hit),
      .el_pfn      (c_pfn),
      .el_nxt      (c_nxt),
      .el_nxt_null (c_nxt_null),
      .rsp_valid   (rsp_valid),
      .rsp_ready   (rsp_ready),
      .rsp_status  (stat),
      .rsp_pfn     (pfn_out),
      .rsp_hops    (rsp_hops)
   );

   assign rsp_status = stat;
   assign rsp_pa     = (stat == WALK_HIT) ? {pfn_out, off_q} : '0;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !el_en && !rsp_valid);
   // R5
   hit_hops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == 2'd0 |-> rsp_hops != '0);

   logic unused_hop;
   assign unused_hop = ^HOP_W;

endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
   localparam int VPN_W    = 20;
   localparam int PFN_W    = 12;
   localparam int OFF_W    = 12;
   localparam int PTR_W    = 6;
   localparam int BKT_W    = 4;
   localparam int MAX_HOPS = 8;
   localparam int HOP_W    = $clog2(MAX_HOPS + 1);
   localparam int ELW      = VPN_W + PFN_W + PTR_W;
   localparam int NBKT     = 1 << BKT_W;
   localparam int NEL      = 1 << PTR_W;
   localparam logic [PTR_W-1:0] NUL = '1;

   logic clk = 0;
   logic rst_n = 0;
   logic req_valid = 0;
   logic req_ready;
   logic [VPN_W+OFF_W-1:0] req_va = '0;
   logic rsp_valid;
   logic rsp_ready = 0;
   logic [1:0] rsp_status;
   logic [PFN_W+OFF_W-1:0] rsp_pa;
   logic [HOP_W-1:0] rsp_hops;
   logic hd_en;
   logic [BKT_W-1:0] hd_addr;
   logic [PTR_W-1:0] hd_ptr;
   logic el_en;
   logic [PTR_W-1:0] el_addr;
   logic [ELW-1:0] el_word;

   logic [PTR_W-1:0] heads [NBKT];
   logic [ELW-1:0]   mem   [NEL];

   int n_chk = 0;
   int n_bad = 0;
   int el_reads = 0;
   int hd_reads = 0;
   logic [BKT_W-1:0] last_hd = '0;
   int cyc = 0;

   always #5 clk = ~clk;

   hpt_walker #(
      .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W),
      .PTR_W(PTR_W), .BKT_W(BKT_W), .MAX_HOPS(MAX_HOPS)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_status(rsp_status), .rsp_pa(rsp_pa), .rsp_hops(rsp_hops),
      .hd_en(hd_en), .hd_addr(hd_addr), .hd_ptr(hd_ptr),
      .el_en(el_en), .el_addr(el_addr), .el_word(el_word)
   );

   always @(posedge clk) begin
      if (hd_en) begin
         hd_ptr   <= heads[hd_addr];
         last_hd  <= hd_addr;
         hd_reads <= hd_reads + 1;
      end
      if (el_en) begin
         el_word  <= mem[el_addr];
         el_reads <= el_reads + 1;
      end
      cyc <= cyc + 1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [BKT_W-1:0] bh(input logic [VPN_W-1:0] v);
      logic [BKT_W-1:0] b = '0;
      for (int i = 0; i < VPN_W; i++) b[i % BKT_W] ^= v[i];
      return b;
   endfunction

   task automatic clear_tab();
      for (int i = 0; i < NBKT; i++) heads[i] = NUL;
      for (int i = 0; i < NEL; i++) mem[i] = '0;
   endtask

   function automatic logic [ELW-1:0] mk(input logic [VPN_W-1:0] v,
                                         input logic [PFN_W-1:0] f,
                                         input logic [PTR_W-1:0] n);
      return {v, f, n};
   endfunction

   task automatic model(input logic [VPN_W-1:0] v, output int st,
                        output logic [PFN_W-1:0] pf, output int hp);
      logic [PTR_W-1:0] p;
      logic [ELW-1:0] e;
      p = heads[bh(v)];
      st = 1; pf = '0; hp = 0;
      while (p != NUL) begin
         e = mem[p];
         hp++;
         if (e[ELW-1 -: VPN_W] == v) begin
            st = 0; pf = e[PTR_W +: PFN_W]; return;
         end
         if (e[PTR_W-1:0] == NUL) return;
         if (hp == MAX_HOPS) begin st = 2; return; end
         p = e[PTR_W-1:0];
      end
   endtask

   task automatic lookup(input logic [VPN_W+OFF_W-1:0] va, input string tag);
      int st, hp, r0, stall;
      logic [PFN_W-1:0] pf;
      logic [1:0] s_keep;
      logic [PFN_W+OFF_W-1:0] pa_keep;
      logic [VPN_W-1:0] v;
      v = va[OFF_W +: VPN_W];
      model(v, st, pf, hp);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      r0 = el_reads;
      req_valid = 1; req_va = va;
      @(posedge clk); #1 req_valid = 0;
      @(negedge clk);
      chk({tag, " R2 head read issued"}, 64'(hd_en), 64'd1);
      chk({tag, " R8 req_ready low while busy"}, 64'(req_ready), 64'd0);
      while (!rsp_valid) @(negedge clk);
      s_keep = rsp_status; pa_keep = rsp_pa;
      stall = int'($urandom_range(0, 3));
      for (int k = 0; k < stall; k++) @(negedge clk);
      chk({tag, " R8 held status"}, 64'(rsp_status), 64'(s_keep));
      chk({tag, " R8 held pa"}, 64'(rsp_pa), 64'(pa_keep));
      chk({tag, " R2 bucket index"}, 64'(last_hd), 64'(bh(v)));
      chk({tag, " R5/R6/R7 status"}, 64'(rsp_status), 64'(st));
      chk({tag, " R5 pa"}, 64'(rsp_pa),
          (st == 0) ? 64'({pf, va[OFF_W-1:0]}) : 64'd0);
      chk({tag, " R4 hops"}, 64'(rsp_hops), 64'(hp));
      chk({tag, " R9 element reads"}, 64'(el_reads - r0), 64'(hp));
      if (hp == 0) chk({tag, " R3 empty bucket is miss"}, 64'(rsp_status), 64'd1);
      rsp_ready = 1;
      @(posedge clk); #1 rsp_ready = 0;
   endtask

   function automatic logic [VPN_W-1:0] vpn_in(input logic [BKT_W-1:0] b,
                                               input logic [VPN_W-1:0] hi);
      logic [VPN_W-1:0] v = hi & ~VPN_W'((1 << BKT_W) - 1);
      return v | VPN_W'(b ^ bh(v));
   endfunction

   task automatic build_chain(input logic [BKT_W-1:0] b, input int len,
                              input int loop_to, input logic [VPN_W-1:0] base);
      for (int i = 0; i < len; i++) begin
         logic [PTR_W-1:0] n;
         n = (i == len - 1) ? ((loop_to >= 0) ? PTR_W'(loop_to) : NUL)
                            : PTR_W'(i + 1);
         mem[i] = mk(base + VPN_W'(i << BKT_W), PFN_W'(12'h100 + i), n);
      end
      heads[b] = '0;
   endtask

   initial begin
      logic [VPN_W-1:0] keys [40];
      logic [VPN_W-1:0] tgt;
      void'($urandom(32'd4242));
      clear_tab();
      hd_ptr = NUL;
      el_word = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset req_ready", 64'(req_ready), 64'd1);
      chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1 reset no reads", 64'(hd_en | el_en), 64'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk("R1 idle no reads", 64'(hd_reads + el_reads), 64'd0);

      // R3: empty table
      lookup({20'h12345, 12'hABC}, "empty");

      // Random table, newest element at chain head
      for (int k = 0; k < 40; k++) begin
         logic [VPN_W-1:0] v;
         logic [BKT_W-1:0] b;
         v = VPN_W'($urandom);
         b = bh(v);
         keys[k] = v;
         mem[k] = mk(v, PFN_W'($urandom), heads[b]);
         heads[b] = PTR_W'(k);
      end
      for (int k = 0; k < 80; k++) begin
         logic [VPN_W-1:0] v;
         v = (k % 2 == 0) ? keys[$urandom_range(0, 39)] : VPN_W'($urandom);
         lookup({v, OFF_W'($urandom)}, "random");
      end

      // Directed chains in bucket 5
      tgt = vpn_in(4'd5, 20'hA0000);
      clear_tab();
      build_chain(4'd5, MAX_HOPS, -1, vpn_in(4'd5, 20'h30000));
      mem[MAX_HOPS-1][ELW-1 -: VPN_W] = tgt;
      lookup({tgt, 12'h055}, "R7 hit on last allowed element");
      mem[MAX_HOPS-1][ELW-1 -: VPN_W] = tgt + 20'h10;
      lookup({tgt, 12'h056}, "R6 miss at chain end");
      clear_tab();
      build_chain(4'd5, MAX_HOPS + 1, -1, vpn_in(4'd5, 20'h30000));
      lookup({tgt, 12'h057}, "R7 over-long chain");
      clear_tab();
      build_chain(4'd5, 2, 0, vpn_in(4'd5, 20'h30000));
      lookup({tgt, 12'h058}, "R7 circular chain");
      mem[1][ELW-1 -: VPN_W] = tgt;
      lookup({tgt, 12'hFFF}, "R5 hit second element");
      mem[0][ELW-1 -: VPN_W] = tgt;
      lookup({tgt, 12'h000}, "R4 first element wins");
      lookup({vpn_in(4'd6, 20'h1), 12'h1}, "R3 other bucket empty");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule